// File: doc/BRIEF.md
# Oscillator Waveform Selector and Combiner

This block sits behind a phase accumulator in a tone generator. Every clock it turns the accumulator, a pulse-width setting, an externally generated noise word and a few control bits into one 12-bit digital sample. It derives a sawtooth, a triangle that can be ring-modulated by a partner oscillator's most significant bit, and a pulse whose threshold compare reaches the output one cycle late. It then merges every selected waveform with a bitwise AND. When noise is merged with any other waveform, it raises a write-back request that carries the merged sample, so the noise register can absorb it.

When no waveform is selected the output floats. A small state machine handles this case. **ST_DRIVE** holds while at least one waveform is selected. **ST_FLOAT** keeps the last sample while a countdown runs. **ST_IDLE** drives zero. The transitions are:
- **go_drive**: from any state on a nonzero select.
- **go_float**: from ST_DRIVE or ST_FLOAT when the select is zero and the countdown has more than one cycle left.
- **go_idle**: from ST_DRIVE or ST_FLOAT when the select is zero and the countdown is on its last cycle.
- **stay_idle**: from ST_IDLE on a zero select.

Reset enters ST_IDLE.

Top module: `wavemix_core`

## Requirements
- R1: After reset the sample output is 0x000, the write-back request is 0 and the write-back data is 0x000.
- R2: With select 4'b0010 (bit 1 = sawtooth) the sample equals accumulator bits 23:12.
- R3: With select 4'b0001 (bit 0 = triangle) the sample is accumulator bits 22:12, each XORed with fold bit accumulator[23], placed in sample bits 11:1, with sample bit 0 = 0.
- R4: When the ring input is 1, the triangle fold bit is accumulator[23] XOR the partner MSB input. When the ring input is 0, the partner MSB has no effect.
- R5: With select 4'b0100 (bit 2 = pulse) the sample is 0xFFF if accumulator[23:12] >= pulse width, else 0x000. The compare result used is the one sampled one clock earlier than the rest of the sample's inputs.
- R6: While the test input is 1, the pulse waveform is 0xFFF regardless of pulse width and accumulator, from the next sample on.
- R7: With several select bits set (bit 3 = noise word), the sample is the bitwise AND of the selected waveforms. Unselected waveforms have no effect.
- R8: With select 0 the sample keeps its last value for FLOAT_TTL clocks and becomes 0x000 on the FLOAT_TTL-th clock. Any nonzero select restarts the full countdown.
- R9: The write-back request is 1 exactly for a sample produced with a select value greater than 4'h8. The write-back data then equals that sample, and is 0x000 when the request is 0.
- R10: The sample and the write-back outputs are registered and change one clock after the inputs they depend on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_i | input | 24 | Phase accumulator value |
| partner_msb_i | input | 1 | MSB of the partner oscillator's accumulator |
| ring_en_i | input | 1 | Ring modulation enable |
| test_i | input | 1 | Test control; forces the pulse level high |
| wave_sel_i | input | 4 | Waveform select: bit0 triangle, bit1 sawtooth, bit2 pulse, bit3 noise |
| pulse_width_i | input | 12 | Pulse width threshold |
| noise_i | input | 12 | Noise waveform word from the noise register |
| sample_o | output | 12 | Registered waveform sample |
| nwb_req_o | output | 1 | Noise write-back request |
| nwb_data_o | output | 12 | Noise write-back data |

## Verification
The assertions assume that the select, accumulator and control inputs are stable across each rising edge and free of X once reset is released. They also assume that FLOAT_TTL is at least one, so the countdown always reaches its last cycle. The stimulus changes inputs only on falling edges. It holds every table vector for two rising edges, so the delayed pulse compare has caught up before each sample is checked. The floating-output tests run with a short countdown, so that both the hold and the drop to zero fall inside a few cycles.

// File: rtl/wavemix_pkg.sv
package wavemix_pkg;

    // Floating-output state machine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_FLOAT = 2'd2
    } mix_state_e;

    // Lane positions inside the select nibble
    localparam int LANES   = 4;
    localparam int LN_TRI  = 0;
    localparam int LN_SAW  = 1;
    localparam int LN_PUL  = 2;
    localparam int LN_NOI  = 3;

endpackage

// File: rtl/wavemix_shapes.sv
module wavemix_shapes #(
    parameter int ACC_W = 24,
    parameter int OUT_W = 12
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             partner_msb,
    input  logic             ring_en,
    output logic [OUT_W-1:0] saw,
    output logic [OUT_W-1:0] tri_w
);
    localparam int TRI_BITS = OUT_W - 1;

    logic                fold;
    logic [TRI_BITS-1:0] body;

    always_comb begin
        saw  = acc[ACC_W-1 -: OUT_W];
        fold = acc[ACC_W-1] ^ (ring_en & partner_msb);
        body = acc[ACC_W-2 -: TRI_BITS] ^ {TRI_BITS{fold}};
        tri_w = {body, 1'b0};
    end
endmodule

// File: rtl/wavemix_pulse.sv
module wavemix_pulse #(
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] phase_top,
    input  logic [OUT_W-1:0] width,
    input  logic             test,
    output logic [OUT_W-1:0] pulse_w
);
    logic cmp_q;

    // Compare is registered: the level reaches the mixer one cycle late
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= 1'b0;
        else        cmp_q <= (phase_top >= width);
    end

    always_comb begin
        pulse_w = {OUT_W{test | cmp_q}};
    end
endmodule

// File: rtl/wavemix_combine.sv
module wavemix_combine #(
    parameter int OUT_W = 12,
    parameter int LANES = 4
) (
    input  logic [LANES-1:0]            sel,
    input  logic [LANES-1:0][OUT_W-1:0] lane,
    output logic [OUT_W-1:0]            mixed
);
    logic [LANES-1:0][OUT_W-1:0] masked;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_mask
            assign masked[g] = sel[g] ? lane[g] : {OUT_W{1'b1}};
        end
    endgenerate

    always_comb begin
        mixed = {OUT_W{1'b1}};
        for (int i = 0; i < LANES; i++) begin
            mixed = mixed & masked[i];
        end
    end
endmodule

// File: rtl/wavemix_core.sv
module wavemix_core
    import wavemix_pkg::*;
#(
    parameter int ACC_W     = 24,
    parameter int OUT_W     = 12,
    parameter int FLOAT_TTL = 65536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [23:0]      acc_i,
    input  logic             partner_msb_i,
    input  logic             ring_en_i,
    input  logic             test_i,
    input  logic [3:0]       wave_sel_i,
    input  logic [11:0]      pulse_width_i,
    input  logic [11:0]      noise_i,
    output logic [11:0]      sample_o,
    output logic             nwb_req_o,
    output logic [11:0]      nwb_data_o
);
    localparam int TTL_W = $clog2(FLOAT_TTL + 1);
    localparam logic [TTL_W-1:0] TTL_LOAD = TTL_W'(FLOAT_TTL);
    localparam logic [TTL_W-1:0] TTL_LAST = TTL_W'(1);

    logic [OUT_W-1:0] saw_w, tri_w, pul_w, mix_w;
    logic [LANES-1:0][OUT_W-1:0] lanes;
    logic             any_sel;
    logic             noise_combo;

    mix_state_e       state_q, state_d;
    logic [TTL_W-1:0] ttl_q;
    logic [OUT_W-1:0] sample_q;
    logic             req_q;

    wavemix_shapes #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_shapes (
        .acc         (acc_i),
        .partner_msb (partner_msb_i),
        .ring_en     (ring_en_i),
        .saw         (saw_w),
        .tri_w       (tri_w)
    );

    wavemix_pulse #(.OUT_W(OUT_W)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_top (acc_i[ACC_W-1 -: OUT_W]),
        .width     (pulse_width_i),
        .test      (test_i),
        .pulse_w   (pul_w)
    );

    always_comb begin
        lanes          = '0;
        lanes[LN_TRI]  = tri_w;
        lanes[LN_SAW]  = saw_w;
        lanes[LN_PUL]  = pul_w;
        lanes[LN_NOI]  = noise_i;
    end

    wavemix_combine #(.OUT_W(OUT_W), .LANES(LANES)) u_combine (
        .sel   (wave_sel_i),
        .lane  (lanes),
        .mixed (mix_w)
    );

    assign any_sel     = |wave_sel_i;
    assign noise_combo = wave_sel_i[LN_NOI] & (|wave_sel_i[LN_PUL:LN_TRI]);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_sel) state_d = ST_DRIVE;      // go_drive
                else         state_d = ST_IDLE;       // stay_idle
            end
            ST_DRIVE, ST_FLOAT: begin
                if (any_sel)                 state_d = ST_DRIVE;  // go_drive
                else if (ttl_q <= TTL_LAST)  state_d = ST_IDLE;   // go_idle
                else                         state_d = ST_FLOAT;  // go_float
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ttl_q   <= '0;
        end else begin
            state_q <= state_d;
            if (any_sel)                 ttl_q <= TTL_LOAD;
            else if (state_d == ST_IDLE) ttl_q <= '0;
            else                         ttl_q <= ttl_q - TTL_LAST;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            req_q    <= 1'b0;
        end else begin
            req_q <= noise_combo;
            unique case (state_d)
                ST_DRIVE: sample_q <= mix_w;
                ST_FLOAT: sample_q <= sample_q;
                ST_IDLE:  sample_q <= '0;
                default:  sample_q <= '0;
            endcase
        end
    end

    assign sample_o   = sample_q;
    assign nwb_req_o  = req_q;
    assign nwb_data_o = req_q ? sample_q : '0;

    // R2
    saw_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_sel_i == 4'b0010) |=> (sample_o == $past(acc_i[23:12])));

    // R7
    and_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_sel_i[LN_NOI]) |=> ((sample_o & ~$past(noise_i)) == 12'h000));

    // R6
    test_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_i && wave_sel_i == 4'b0100) |=> (sample_o == 12'hFFF));

    // R8
    float_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLOAT && wave_sel_i == 4'b0000) |=>
        (sample_o == $past(sample_o) || sample_o == 12'h000));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (sample_o == 12'h000));

    // R9
    wb_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_sel_i > 4'h8) |=> (nwb_req_o && nwb_data_o == sample_o));

endmodule

// File: tb/sim_wavemix_core.sv
module sim_wavemix_core;
    localparam int TTL = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] acc;
    logic        pmsb, ring, test;
    logic [3:0]  sel;
    logic [11:0] pw, noise;
    logic [11:0] sample, wb_data;
    logic        wb_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wavemix_core #(.FLOAT_TTL(TTL)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_i(acc), .partner_msb_i(pmsb),
        .ring_en_i(ring), .test_i(test), .wave_sel_i(sel),
        .pulse_width_i(pw), .noise_i(noise), .sample_o(sample),
        .nwb_req_o(wb_req), .nwb_data_o(wb_data)
    );

    typedef struct packed {
        logic [3:0]  sel;
        logic        test;
        logic        ring;
        logic        pmsb;
        logic [23:0] acc;
        logic [11:0] pw;
        logic [11:0] noise;
        logic [11:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'h2, 1'b0, 1'b0, 1'b0, 24'hABC123, 12'hFFF, 12'h000, 12'hABC}, // R2
        '{4'h1, 1'b0, 1'b0, 1'b0, 24'h3A5000, 12'h000, 12'h000, 12'h74A}, // R3 rising
        '{4'h1, 1'b0, 1'b0, 1'b0, 24'hC35000, 12'h000, 12'h000, 12'h794}, // R3 falling
        '{4'h1, 1'b0, 1'b1, 1'b1, 24'h3A5000, 12'h000, 12'h000, 12'h8B4}, // R4
        '{4'h1, 1'b0, 1'b1, 1'b1, 24'hC35000, 12'h000, 12'h000, 12'h86A}, // R4
        '{4'h1, 1'b0, 1'b0, 1'b1, 24'h3A5000, 12'h000, 12'h000, 12'h74A}, // R4 ring off
        '{4'h4, 1'b0, 1'b0, 1'b0, 24'h800000, 12'h800, 12'h000, 12'hFFF}, // R5 equal
        '{4'h4, 1'b0, 1'b0, 1'b0, 24'h7FF000, 12'h800, 12'h000, 12'h000}, // R5 below
        '{4'h4, 1'b1, 1'b0, 1'b0, 24'h000000, 12'hFFF, 12'h000, 12'hFFF}, // R6
        '{4'h8, 1'b0, 1'b0, 1'b0, 24'h000000, 12'h000, 12'h5A5, 12'h5A5}, // R7 noise
        '{4'h3, 1'b0, 1'b0, 1'b0, 24'h3A5000, 12'h000, 12'h000, 12'h300}, // R7 saw+tri
        '{4'h6, 1'b0, 1'b0, 1'b0, 24'hABC123, 12'h100, 12'h000, 12'hABC}, // R7 saw+pulse
        '{4'h6, 1'b0, 1'b0, 1'b0, 24'hABC123, 12'hFFF, 12'h000, 12'h000}, // R7 pulse low
        '{4'hA, 1'b0, 1'b0, 1'b0, 24'hABC123, 12'h000, 12'hF0F, 12'hA0C}  // R9 noise+saw
    };

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=%h exp=%h", 1'b0, 1'b1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc = '0; pmsb = 0; ring = 0; test = 0;
        sel = '0; pw = '0; noise = '0;
        step(3);
        // R1 reset state
        check("R1 sample", sample, 12'h000);
        check("R1 req", {11'd0, wb_req}, 12'h000);
        check("R1 data", wb_data, 12'h000);
        rst_n = 1'b1;

        // Vector table: each held for two edges so the pulse compare settles
        for (int i = 0; i < NV; i++) begin
            sel = VEC[i].sel; test = VEC[i].test; ring = VEC[i].ring;
            pmsb = VEC[i].pmsb; acc = VEC[i].acc; pw = VEC[i].pw;
            noise = VEC[i].noise;
            step(2);
            check($sformatf("R7 vec%0d sample", i), sample, VEC[i].exp);
            check($sformatf("R9 vec%0d req", i), {11'd0, wb_req},
                  {11'd0, (VEC[i].sel > 4'h8)});
            check($sformatf("R9 vec%0d data", i), wb_data,
                  (VEC[i].sel > 4'h8) ? VEC[i].exp : 12'h000);
        end
        test = 0; ring = 0; pmsb = 0; noise = '0;

        // R5 one-cycle compare delay, R10 registered latency
        sel = 4'h4; pw = 12'h800; acc = 24'h7FF000;
        step(2);
        check("R5 low", sample, 12'h000);
        acc = 24'h800000;
        step(1);
        check("R5 delayed", sample, 12'h000);
        step(1);
        check("R5 high", sample, 12'hFFF);
        // R6 test forces high on the next sample
        acc = 24'h000000; test = 1;
        step(1);
        check("R6 forced", sample, 12'hFFF);
        test = 0;
        step(1);
        check("R6 released", sample, 12'h000);

        // R10 saw follows after one edge
        sel = 4'h2; acc = 24'h123000;
        step(1);
        check("R10 latency", sample, 12'h123);

        // R8 float hold then zero
        acc = 24'hABC123;
        step(1);
        check("R8 drive", sample, 12'hABC);
        sel = 4'h0; acc = 24'h555555;
        step(TTL - 1);
        check("R8 hold", sample, 12'hABC);
        step(1);
        check("R8 zero", sample, 12'h000);

        // R8 countdown restart on nonzero select
        sel = 4'h2; acc = 24'h777000;
        step(1);
        sel = 4'h0;
        step(3);
        check("R8 partial", sample, 12'h777);
        sel = 4'h2;
        step(1);
        sel = 4'h0;
        step(TTL - 1);
        check("R8 reload hold", sample, 12'h777);
        step(1);
        check("R8 reload zero", sample, 12'h000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule